// File: doc/BRIEF.md
# Two-Bit Sum-or-Compare Unit

This block is a purely combinational arithmetic helper for a small datapath. It takes two unsigned operands and a single mode bit. With the mode bit high it returns the unsigned sum of the operands, and the carry lands in the top result bit. With the mode bit low it returns a short code that describes how the two operands compare in magnitude.

Inside, the block has three parts. A ripple adder produces the sum and carry. A magnitude comparator has its own enable input, and that enable is held active inside this block. A result selector places either the adder output or the zero-extended comparison code on the shared result port.

There is no clock and no storage. The result follows the present inputs only, so a host can change the mode and the operands on any cycle and read the answer in the same cycle.

Top module: `addcmp_unit`

## Requirements
- R1: With `mode_add` = 1 and no carry out of the operand width, `res` equals the unsigned sum `op_a + op_b`. The top bit `res[2]` is 0.
- R2: With `mode_add` = 1, an unsigned sum of 4 or more sets `res[2]` = 1, and `res[1:0]` holds the low two sum bits. For example, 3 + 3 gives `res` = 3'b110.
- R3: With `mode_add` = 0 and `op_a` < `op_b`, `res` = 3'b001.
- R4: With `mode_add` = 0 and `op_a` > `op_b`, `res` = 3'b010.
- R5: With `mode_add` = 0 and `op_a` = `op_b`, `res` = 3'b011.
- R6: With `mode_add` = 0, `res[2]` is always 0 and `res` is never 3'b000, because the internal comparator is always enabled.
- R7: `res` depends only on the present inputs. If `mode_add` is toggled while the operands are held, `res` switches between the sum and the comparison code with no memory of earlier values.
- R8: The comparison is unsigned. For example, `op_a` = 2'b10 against `op_b` = 2'b01 gives the greater-than code 3'b010.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 2 | First unsigned operand |
| op_b | input | 2 | Second unsigned operand |
| mode_add | input | 1 | 1 selects sum, 0 selects comparison code |
| res | output | 3 | Sum with carry on top, or the zero-extended comparison code |

## Verification
The bench visits all 32 input combinations and then goes after specific corner cases.

- **Carry.** Operand pairs whose sum reaches 4 expose an adder that drops or misplaces the carry; such a design would report 3 + 3 as 2 instead of 6.
- **Signed comparison.** Pairs such as 2 against 1 expose a comparator that treats the top bit as a sign; it would report "less than" where "greater than" is correct.
- **Comparator enable.** In compare mode the bench checks that the top bit is clear and that the result is never zero. A comparator left disabled would output 000, and a selector that leaks the carry would set bit 2.
- **Mode toggling.** Toggling the mode with the operands held catches a selector with inverted polarity or with retained state.

// File: rtl/addcmp_pkg.sv
// Package: shared constants for the sum-or-compare unit.
// Assumes: comparison codes are two bits wide and fixed by the block's
// behaviour (1 = less, 2 = greater, 3 = equal, 0 = comparator disabled).
package addcmp_pkg;

    localparam int CODE_W = 2;

    localparam logic [CODE_W-1:0] CODE_OFF  = 2'd0;
    localparam logic [CODE_W-1:0] CODE_LESS = 2'd1;
    localparam logic [CODE_W-1:0] CODE_MORE = 2'd2;
    localparam logic [CODE_W-1:0] CODE_SAME = 2'd3;

endpackage

// File: rtl/addcmp_ripple.sv
// Module: addcmp_ripple
// Ripple-carry adder for two unsigned W-bit operands, with the carry-in
// tied to zero.
// Assumes: W >= 1. Purely combinational.
module addcmp_ripple #(
    parameter int W = 2
) (
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] sum_out,
    output logic         carry_out
);

    logic [W:0] chain;

    assign chain[0] = 1'b0;

    // One full-adder cell per operand bit
    for (genvar g = 0; g < W; g++) begin : g_cell
        assign sum_out[g]   = a_in[g] ^ b_in[g] ^ chain[g];
        assign chain[g+1]   = (a_in[g] & b_in[g])
                            | (a_in[g] & chain[g])
                            | (b_in[g] & chain[g]);
    end

    assign carry_out = chain[W];

endmodule

// File: rtl/addcmp_magcmp.sv
// Module: addcmp_magcmp
// Unsigned magnitude comparator with a gating enable. When the enable is
// high it outputs the less, greater or equal code; when it is low it
// outputs the off code.
// Assumes: W >= 1. Operands are unsigned. Purely combinational.
module addcmp_magcmp
    import addcmp_pkg::*;
#(
    parameter int W = 2
) (
    input  logic              cmp_en,
    input  logic [W-1:0]      a_in,
    input  logic [W-1:0]      b_in,
    output logic [CODE_W-1:0] code_out
);

    logic a_lt;
    logic a_gt;

    // Scan from LSB to MSB so the highest differing bit decides the result
    always_comb begin
        a_lt = 1'b0;
        a_gt = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (a_in[i] != b_in[i]) begin
                a_lt = b_in[i];
                a_gt = a_in[i];
            end
        end
    end

    // Map the relation to a code, with the enable gating everything off
    always_comb begin
        if (!cmp_en)
            code_out = CODE_OFF;
        else if (a_lt)
            code_out = CODE_LESS;
        else if (a_gt)
            code_out = CODE_MORE;
        else
            code_out = CODE_SAME;
    end

endmodule

// File: rtl/addcmp_sel.sv
// Module: addcmp_sel
// Result selector. It places the carry and sum, or the zero-extended
// comparison code, on the shared result bus.
// Assumes: W >= CODE_W. Purely combinational.
module addcmp_sel
    import addcmp_pkg::*;
#(
    parameter int W = 2
) (
    input  logic              pick_sum,
    input  logic [W-1:0]      sum_in,
    input  logic              carry_in,
    input  logic [CODE_W-1:0] code_in,
    output logic [W:0]        res_out
);

    localparam int PAD_W = W + 1 - CODE_W;

    // Choose the arithmetic or the relational view of the operands
    always_comb begin
        if (pick_sum)
            res_out = {carry_in, sum_in};
        else
            res_out = {{PAD_W{1'b0}}, code_in};
    end

endmodule

// File: rtl/addcmp_unit.sv
// Module: addcmp_unit (top)
// Mode-selectable unsigned adder or magnitude comparator on a shared
// result port.
// Assumes: unsigned operands, W >= 2, no clock. The comparator enable is
// held active here, so compare mode never returns the off code.
module addcmp_unit #(
    parameter int W = 2
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         mode_add,
    output logic [W:0]   res
);

    import addcmp_pkg::*;

    localparam logic CMP_ALWAYS_ON = 1'b1;

    logic [W-1:0]      sum_w;
    logic              carry_w;
    logic [CODE_W-1:0] code_w;

    addcmp_ripple #(.W(W)) u_add (
        .a_in     (op_a),
        .b_in     (op_b),
        .sum_out  (sum_w),
        .carry_out(carry_w)
    );

    addcmp_magcmp #(.W(W)) u_cmp (
        .cmp_en  (CMP_ALWAYS_ON),
        .a_in    (op_a),
        .b_in    (op_b),
        .code_out(code_w)
    );

    addcmp_sel #(.W(W)) u_sel (
        .pick_sum(mode_add),
        .sum_in  (sum_w),
        .carry_in(carry_w),
        .code_in (code_w),
        .res_out (res)
    );

endmodule

// File: rtl/addcmp_chk.sv
// Module: addcmp_chk
// Assertion checker bound to addcmp_unit. It relates the result port to
// the operand and mode ports.
// Assumes: purely combinational target, so it uses immediate assertions.
module addcmp_chk #(
    parameter int W = 2
) (
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic         mode_add,
    input logic [W:0]   res
);

    logic [W:0] wide_sum;

    assign wide_sum = {1'b0, op_a} + {1'b0, op_b};

    // Check every result against the operands and the mode
    always_comb begin
        if (mode_add) begin
            AST_SUM_MATCH: assert (res == wide_sum);                      // R1
            AST_CARRY_TOP: assert (res[W] == (wide_sum >= (W+1)'(1 << W))); // R2
        end else begin
            AST_CMP_TOP_CLEAR: assert (res[W] == 1'b0);                   // R6
            AST_CMP_NEVER_OFF: assert (res != '0);                        // R6
            if (op_a < op_b) begin
                AST_CMP_LESS: assert (res == (W+1)'(1));                  // R3
            end
            if (op_a > op_b) begin
                AST_CMP_MORE: assert (res == (W+1)'(2));                  // R4
            end
            if (op_a == op_b) begin
                AST_CMP_SAME: assert (res == (W+1)'(3));                  // R5
            end
        end
    end

endmodule

bind addcmp_unit addcmp_chk #(.W(W)) u_chk (
    .op_a    (op_a),
    .op_b    (op_b),
    .mode_add(mode_add),
    .res     (res)
);

// File: tb/test_addcmp_unit.sv
// Scoreboard bench for addcmp_unit. The driver applies inputs at the rising
// edge and queues the expected result. The monitor compares at the
// falling edge.
module test_addcmp_unit;

    localparam int W = 2;

    typedef struct {
        logic [W:0] exp;
        string      tag;
        logic       only_flags;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         mode_add = 1'b0;
    logic [W:0]   res;

    int    n_chk = 0;
    int    n_bad = 0;
    item_t sb_q[$];

    always #2.5 clk = ~clk;

    addcmp_unit #(.W(W)) i_addcmp_unit (
        .op_a    (op_a),
        .op_b    (op_b),
        .mode_add(mode_add),
        .res     (res)
    );

    // Reference model built from the requirements
    function automatic logic [W:0] ref_res(input int a, input int b, input logic m);
        if (m) return (W+1)'(a + b);
        if (a < b) return 3'b001;
        if (a > b) return 3'b010;
        return 3'b011;
    endfunction

    function automatic string ref_tag(input int a, input int b, input logic m);
        if (m) return (a + b >= 4) ? "R2" : "R1";
        if (a < b) return "R3";
        if (a > b) return "R4";
        return "R5";
    endfunction

    // Driver: apply one input set and queue its expectations
    task automatic drive(input int a, input int b, input logic m, input string tag_ovr);
        item_t it;
        @(posedge clk);
        op_a     = W'(a);
        op_b     = W'(b);
        mode_add = m;
        it.exp        = ref_res(a, b, m);
        it.tag        = (tag_ovr != "") ? tag_ovr : ref_tag(a, b, m);
        it.only_flags = 1'b0;
        sb_q.push_back(it);
        if (!m) begin
            it.tag        = "R6";
            it.only_flags = 1'b1;
            sb_q.push_back(it);
        end
    endtask

    // Monitor: pop and compare once the outputs have settled
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_chk++;
            if (it.only_flags) begin
                if (res[W] !== 1'b0 || res === '0) begin
                    n_bad++;
                    $display("FAIL %s: res=%b expected top clear and nonzero", it.tag, res);
                end
            end else if (res !== it.exp) begin
                n_bad++;
                $display("FAIL %s: a=%0d b=%0d mode=%0b res=%b expected=%b",
                         it.tag, op_a, op_b, mode_add, res, it.exp);
            end
        end
    end

    // Watchdog: a hung run is counted as a failure
    initial begin
        repeat (5000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    // Stimulus sequence
    initial begin
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        drive(0, 0, 1'b0, "R5");          // state after reset, compare of zeros
        drive(3, 3, 1'b1, "R2");          // largest carry case
        drive(2, 1, 1'b0, "R8");          // unsigned greater-than
        drive(1, 2, 1'b0, "R8");          // unsigned less-than
        drive(3, 1, 1'b1, "R2");
        drive(1, 2, 1'b1, "R1");
        // R7: toggle the mode with the operands held
        drive(2, 3, 1'b0, "R7");
        drive(2, 3, 1'b1, "R7");
        drive(2, 3, 1'b0, "R7");
        // Exhaustive sweep
        for (int m = 0; m < 2; m++)
            for (int a = 0; a < 4; a++)
                for (int b = 0; b < 4; b++)
                    drive(a, b, m[0], "");
        repeat (3) @(posedge clk);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule